// File: doc/BRIEF.md
# Clock-Synchronous Serial Shifter

This block is an 8-bit clock-synchronous serial port. One shift register serves both directions. The bits to send leave on the serial output, and the bits that arrive on the serial input fill the vacated positions. When the eighth bit is done, the register holds the received byte. The host configures the port through three write-only registers and starts a transfer by writing the byte to send. It reads the received byte on a dedicated output.

The port can generate its own serial clock or take one from outside. With its own clock, the serial clock rests high. Its half period is the system clock period times the rate value plus one, times the prescaler division. After eight cycles it stops by itself, and the data output holds its last bit for one more half period before releasing. With an outside clock, the clock pin passes through a synchronizer, and the block shifts on every edge it sees. When no transfer is active, the data output shows a programmable idle level. A one-cycle interrupt pulse marks the end of each byte.

Top module: `sio_shifter`

## Requirements
- R1: After reset the block has the following state: `sclk_o`=1, `sclk_oe`=0, `sout_oe`=0, `busy`=0, `irq`=0, `err`=0 and `rx_data`=0. The reset configuration is internal clock, division by 1, MSB first, idle level 0 and port disabled.
- R2: Registers are selected by `reg_addr`: 0 is the data register, 1 is control and 2 is the rate register. Address 3 holds no register.
  - Control register fields: bit 0 selects the outside clock; bits 2:1 select the prescaler (0 divides by 1, 1 by 8, 2 and 3 by 32); bit 3 selects LSB first; bit 4 is the idle level; bit 5 is port enable.
  - With the internal clock, the half period is H = (rate+1) x division system cycles. `sclk_o` first falls H cycles after the data write and then toggles every H cycles.
- R3: With the internal clock, exactly 8 falling and 8 rising edges are produced, and the clock then rests high. `irq` is high for one cycle, in the cycle of the eighth rising edge, when `busy` also drops.
- R4: `sout` changes only at falling edges of the serial clock. Bit k of the transfer is `tx[k]` in LSB-first order and `tx[7-k]` in MSB-first order.
- R5: `sin` is sampled at each rising edge. After the eighth edge, `rx_data` holds the received byte, with the first bit in bit 0 (LSB first) or bit 7 (MSB first).
- R6: With the internal clock, `sout_oe` rises at the first falling edge. It stays high for H cycles after the eighth rising edge and then falls.
- R7: Any register write that lands during that hold period drops `sout_oe` in the next cycle. This includes a write to address 3.
- R8: A data write while `busy` is ignored: the transfer and the bits it sends and receives are unchanged. It sets `err`, which stays set until reset.
- R9: With the outside clock, `sout_oe` equals port enable. `sout` shows the idle level except during a transfer, where it changes at synchronized falling edges of `sclk_i`.
- R10: With the outside clock, edges after the eighth keep shifting the register. They raise no `irq` and leave `busy` low.
- R11: A data write while the port is disabled loads `rx_data` but starts no transfer.
- R12: `sclk_oe` is high only when the port is enabled and the internal clock is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| rx_data | output | 8 | Shift register contents (received byte) |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Sticky flag for a write while busy |
| irq | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Serial clock drive enable |
| sclk_i | input | 1 | Serial clock from outside |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Serial data drive enable |
| sin | input | 1 | Serial data in |

## Verification
Two events can fall on the same clock edge: the end of the hold period, and a host register write that cuts the hold short. Both clear the output enable. The bench times a write to address 2 so that it is captured on the very edge where the hold counter expires. It then checks that `sout_oe` falls exactly once, after exactly 17 half periods, with no extra cycle of drive. A second vector places a write one cycle after the final rising edge, to judge the early cut on its own.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_RATE = 2'd2;

  localparam int PRESC_LOG2_MAX = 5;

  typedef struct packed {
    logic       port_en;
    logic       idle_lvl;
    logic       lsb_first;
    logic [1:0] presc_sel;
    logic       ext_clk;
  } ctrl_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_XFER = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;

  function automatic logic [2:0] presc_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd0;
      2'd1:    return 3'd3;
      default: return 3'(PRESC_LOG2_MAX);
    endcase
  endfunction

endpackage

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output ctrl_t             ctrl,
  output logic [RATE_W-1:0] rate
);

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_d;
  logic [RATE_W-1:0] rate_d;

  always_comb begin
    ctrl_d = ctrl;
    rate_d = rate;
    if (reg_wr && reg_addr == ADDR_CTRL) ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    if (reg_wr && reg_addr == ADDR_RATE) rate_d = reg_wdata[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      rate <= '0;
    end else begin
      ctrl <= ctrl_d;
      rate <= rate_d;
    end
  end

endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int RATE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        presc_sel,
  input  logic [RATE_W-1:0] rate,
  input  logic              load,
  input  logic              count_en,
  input  logic              sclk_pin,
  output logic              tick,
  output logic              ext_rise,
  output logic              ext_fall
);

  localparam int CNT_W = RATE_W + 1 + PRESC_LOG2_MAX;

  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SYNC_N:0]   sync_q, sync_d;

  always_comb begin
    reload = ((CNT_W'(rate) + CNT_W'(1)) << presc_log2(presc_sel)) - CNT_W'(1);
    tick   = count_en && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (load || tick)  cnt_d = reload;
    else if (count_en) cnt_d = cnt_q - CNT_W'(1);
  end

  // synchronizer stages plus one history stage for edge detection
  for (genvar i = 0; i <= SYNC_N; i++) begin : g_sync
    if (i == 0) begin : g_first
      assign sync_d[i] = sclk_pin;
    end else begin : g_next
      assign sync_d[i] = sync_q[i-1];
    end
  end

  assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign ext_fall = ~sync_q[SYNC_N-1] & sync_q[SYNC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= '1;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

endmodule

// File: rtl/sio_shift.sv
module sio_shift
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              data_wr,
  input  logic              any_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  input  logic              ext_rise,
  input  logic              ext_fall,
  input  logic              sin,
  output logic              load,
  output logic              count_en,
  output logic              sclk_q,
  output logic              sout,
  output logic              sout_oe,
  output logic              busy,
  output logic              err,
  output logic              irq,
  output logic [DATA_W-1:0] rx_data
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              out_q, out_d;
  logic              oe_q, oe_d;
  logic              sclk_d, err_d, irq_d;
  logic              ext, wr_ok, go, shift_ok, rise_ev, fall_ev;

  always_comb begin
    ext      = ctrl.ext_clk;
    wr_ok    = data_wr && (phase_q != PH_XFER);
    go       = wr_ok && ctrl.port_en;
    shift_ok = ext ? ctrl.port_en : (phase_q == PH_XFER);
    rise_ev  = ext ? ext_rise : (tick && !sclk_q);
    fall_ev  = ext ? ext_fall : (tick && sclk_q);
    load     = go;
    count_en = !ext && (phase_q != PH_IDLE);
  end

  always_comb begin
    phase_d = phase_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    out_d   = out_q;
    oe_d    = oe_q;
    sclk_d  = sclk_q;
    err_d   = err;
    irq_d   = 1'b0;

    if (phase_q == PH_HOLD && (tick || any_wr)) begin
      oe_d    = 1'b0;
      phase_d = PH_IDLE;
    end

    if (data_wr && phase_q == PH_XFER) err_d = 1'b1;

    if (wr_ok) begin
      sh_d  = wr_data;
      bit_d = '0;
      if (go) begin
        phase_d = PH_XFER;
        sclk_d  = 1'b1;
        if (ext) out_d = ctrl.idle_lvl;
      end
    end else if (shift_ok) begin
      if (fall_ev) begin
        out_d = ctrl.lsb_first ? sh_q[0] : sh_q[DATA_W-1];
        if (!ext) begin
          oe_d   = 1'b1;
          sclk_d = 1'b0;
        end
      end
      if (rise_ev) begin
        sh_d = ctrl.lsb_first ? {sin, sh_q[DATA_W-1:1]} : {sh_q[DATA_W-2:0], sin};
        if (!ext) sclk_d = 1'b1;
        if (phase_q == PH_XFER) begin
          bit_d = bit_q + BIT_W'(1);
          if (bit_q == LAST_BIT) begin
            irq_d   = 1'b1;
            phase_d = ext ? PH_IDLE : PH_HOLD;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
      sclk_q  <= 1'b1;
      err     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
      sclk_q  <= sclk_d;
      err     <= err_d;
      irq     <= irq_d;
    end
  end

  assign busy    = (phase_q == PH_XFER);
  assign rx_data = sh_q;
  assign sout    = (ext && phase_q != PH_XFER) ? ctrl.idle_lvl : out_q;
  assign sout_oe = ext ? ctrl.port_en : oe_q;

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              err,
  output logic              irq,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              sclk_i,
  output logic              sout,
  output logic              sout_oe,
  input  logic              sin
);

  ctrl_t             ctrl;
  logic [RATE_W-1:0] rate;
  logic              load, count_en, tick, ext_rise, ext_fall, data_wr;

  assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
  assign sclk_oe = ctrl.port_en & ~ctrl.ext_clk;

  sio_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctrl      (ctrl),
    .rate      (rate)
  );

  sio_clkgen #(.RATE_W(RATE_W), .SYNC_N(SYNC_N)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_sel (ctrl.presc_sel),
    .rate      (rate),
    .load      (load),
    .count_en  (count_en),
    .sclk_pin  (sclk_i),
    .tick      (tick),
    .ext_rise  (ext_rise),
    .ext_fall  (ext_fall)
  );

  sio_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .data_wr  (data_wr),
    .any_wr   (reg_wr),
    .wr_data  (reg_wdata),
    .tick     (tick),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .sin      (sin),
    .load     (load),
    .count_en (count_en),
    .sclk_q   (sclk_o),
    .sout     (sout),
    .sout_oe  (sout_oe),
    .busy     (busy),
    .err      (err),
    .irq      (irq),
    .rx_data  (rx_data)
  );

endmodule

// File: rtl/sio_chk.sv
module sio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       busy,
  input logic       err,
  input logic       irq,
  input logic       sclk_o,
  input logic       sclk_oe,
  input logic       sout,
  input logic       sout_oe
);

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R3
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));

  // R3
  clock_rests_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);

  // R8
  busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd0) |=> err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R4
  sout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && $past(sclk_oe) && busy && $past(busy) && sout_oe && !$fell(sclk_o))
      |-> $stable(sout));

endmodule

bind sio_shifter sio_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .busy     (busy),
  .err      (err),
  .irq      (irq),
  .sclk_o   (sclk_o),
  .sclk_oe  (sclk_oe),
  .sout     (sout),
  .sout_oe  (sout_oe)
);

// File: tb/sim_sio_shifter.sv
module sim_sio_shifter;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] rx_data;
  logic       busy, err, irq, sclk_o, sclk_oe, sclk_i, sout, sout_oe, sin;

  int n_chk  = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  bit done = 0;
  bit err_exp = 0;

  sio_shifter u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_data   (rx_data),
    .busy      (busy),
    .err       (err),
    .irq       (irq),
    .sclk_o    (sclk_o),
    .sclk_oe   (sclk_oe),
    .sclk_i    (sclk_i),
    .sout      (sout),
    .sout_oe   (sout_oe),
    .sin       (sin)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  // vector: {sel[36:35], rate[34:27], lsb[26], tx[25:18], rx[17:10], inj_m[9:2], inj_addr[1:0]}
  localparam logic [36:0] VECS [6] = '{
    {2'd0, 8'd0, 1'b0, 8'hA5, 8'h3C, 8'd255, 2'd0},
    {2'd0, 8'd2, 1'b1, 8'h81, 8'hE7, 8'd48,  2'd3},
    {2'd0, 8'd2, 1'b0, 8'h5A, 8'h96, 8'd50,  2'd2},
    {2'd1, 8'd1, 1'b1, 8'hC3, 8'h0F, 8'd3,   2'd0},
    {2'd2, 8'd0, 1'b0, 8'h00, 8'hFF, 8'd255, 2'd0},
    {2'd3, 8'd0, 1'b1, 8'hFF, 8'h00, 8'd255, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_xfer(input logic [36:0] v);
    logic [1:0] sel;
    logic [7:0] rate, tx, rx, injm;
    logic [1:0] inja;
    logic       lsb;
    int h, cut, div;
    logic [5:0] act, exp;
    {sel, rate, lsb, tx, rx, injm, inja} = v;
    div = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 8 : 32;
    h   = (int'(rate) + 1) * div;
    cut = (injm != 8'd255 && int'(injm) >= 16*h) ? int'(injm) + 1 : 17*h;
    wr(2'd1, 8'h20 | (8'(lsb) << 3) | (8'(sel) << 1));
    wr(2'd2, rate);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = tx;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    chk(sclk_oe == 1'b1, "R12 sclk_oe internal enabled", 32'(sclk_oe), 1);
    for (int m = 0; m <= 17*h + 1; m++) begin
      reg_wr = 1'b0;
      if (injm != 8'd255 && m == int'(injm)) begin
        reg_wr = 1'b1; reg_addr = inja;
        reg_wdata = (inja == 2'd2) ? rate : 8'hFF;
        if (inja == 2'd0 && m < 16*h) err_exp = 1'b1;
      end
      for (int k = 0; k < 8; k++)
        if (m == (2*k + 1)*h) sin = lsb ? rx[k] : rx[7-k];
      begin
        int k;
        logic sb;
        k = (m >= h) ? (m - h) / (2*h) : 0;
        if (k > 7) k = 7;
        sb = lsb ? tx[k] : tx[7-k];
        exp[5] = (m < 16*h) ? (((m / h) % 2) == 0) : 1'b1;
        exp[4] = (m == 16*h);
        exp[3] = (m >= h && m < cut);
        exp[2] = (m < 16*h);
        exp[1] = (injm != 8'd255 && inja == 2'd0 && m > int'(injm)) ? 1'b1 : err_exp & (injm == 8'd255 || inja != 2'd0 || m > int'(injm));
        exp[0] = exp[3] & sb;
        act = {sclk_o, irq, sout_oe, busy, err, sout & sout_oe};
        chk(act == exp, $sformatf("R2 R3 R4 R6 R7 R8 m=%0d h=%0d {sclk,irq,oe,busy,err,sout}", m, h),
            32'(act), 32'(exp));
      end
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk(rx_data == rx, "R5 received byte", 32'(rx_data), 32'(rx));
  endtask

  task automatic ext_half(input logic lvl);
    sclk_i = lvl;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int irq0;
    logic [7:0] tx, rx, rx2;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    sclk_i = 1'b1; sin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({sclk_o, sclk_oe, sout_oe, busy, irq, err} == 6'b100000, "R1 reset outputs",
        32'({sclk_o, sclk_oe, sout_oe, busy, irq, err}), 32'h20);
    chk(rx_data == 8'h00, "R1 reset rx_data", 32'(rx_data), 0);
    // R12 port disabled by default
    chk(sclk_oe == 1'b0, "R12 sclk_oe reset", 32'(sclk_oe), 0);

    // R11 port disabled: load without transfer
    wr(2'd0, 8'hC3);
    repeat (4) @(negedge clk);
    chk(rx_data == 8'hC3, "R11 data loaded", 32'(rx_data), 32'hC3);
    chk({busy, sclk_o, sout_oe} == 3'b010, "R11 no transfer", 32'({busy, sclk_o, sout_oe}), 2);

    for (int i = 0; i < 6; i++) run_xfer(VECS[i]);
    chk(err == 1'b1, "R8 err sticky", 32'(err), 1);

    // external clock, MSB first, idle level 1
    wr(2'd1, 8'h31);
    chk({sout_oe, sout, sclk_oe} == 3'b110, "R9 R12 ext idle", 32'({sout_oe, sout, sclk_oe}), 6);
    tx = 8'hA5; rx = 8'h6B; rx2 = 8'h3C;
    irq0 = irq_cnt;
    wr(2'd0, tx);
    chk({busy, sout} == 2'b11, "R9 ext start idle level", 32'({busy, sout}), 3);
    for (int k = 0; k < 8; k++) begin
      ext_half(1'b0);
      chk(sout == tx[7-k], $sformatf("R9 ext bit %0d", k), 32'(sout), 32'(tx[7-k]));
      sin = rx[7-k];
      ext_half(1'b1);
    end
    chk(irq_cnt - irq0 == 1, "R3 ext one irq", 32'(irq_cnt - irq0), 1);
    chk(rx_data == rx, "R5 ext received", 32'(rx_data), 32'(rx));
    chk({busy, sout} == 2'b01, "R9 ext back to idle", 32'({busy, sout}), 1);
    for (int k = 0; k < 8; k++) begin
      ext_half(1'b0);
      sin = rx2[7-k];
      ext_half(1'b1);
    end
    chk(rx_data == rx2, "R10 extra edges shift", 32'(rx_data), 32'(rx2));
    chk(irq_cnt - irq0 == 1, "R10 no extra irq", 32'(irq_cnt - irq0), 1);
    chk({busy, sout} == 2'b01, "R10 busy low idle out", 32'({busy, sout}), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule